// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Walk

This block converts a virtual address into a physical address. The virtual address has two fields. The upper field is the virtual page number. The lower field is the byte offset, which passes through unchanged. The page number is first looked up in a small fully associative buffer that holds recently used page-to-frame pairs. On a hit, the physical address is the stored frame number placed above the offset, and the result is ready one cycle after the request is accepted.

On a miss, the block reads one page-table word through a request/acknowledge memory port. The word address is a table base input plus the virtual page number, and the memory may take any number of cycles to answer. The returned word has a resident flag and a frame number. If the flag is set, the pair is installed in the buffer and the translation completes. If the flag is clear, the block pulses a fault output with the page number instead. The requester may repeat the access once the page has been made resident. A single-cycle invalidate input empties the whole buffer.

Top module: `xlate_unit`

## Requirements
- R1: After reset `done`, `fault` and `mem_req` are low, `ready` is high, and every buffer entry is empty, so the first access to any page walks the table.
- R2: The low `OFS_W` bits of `paddr` equal the low `OFS_W` bits of the accepted `vaddr`, whether the translation was a hit or a walk.
- R3: A request is accepted on a rising edge where `req_valid` and `ready` are both high. If its page number (`vaddr[VA_W-1:OFS_W]`) matches a valid entry, `done` is high in the cycle right after acceptance, `paddr` equals {stored frame, offset}, and no memory read is issued.
- R4: On a miss, `mem_req` goes high in the cycle after acceptance with `mem_addr = pt_base + page number`. Both stay unchanged until the rising edge where `mem_ack` is high.
- R5: The table word on `mem_rdata` has the resident flag at bit `PFN_W` and the frame number in bits `PFN_W-1:0`. When the flag is 1 at the acknowledging edge, `done` pulses in the next cycle with `paddr` = {frame, offset}, and a later access to the same page hits.
- R6: When the flag is 0, `fault` pulses for one cycle in the next cycle with `fault_vpn` equal to the page number, `done` stays low, and nothing is installed, so repeating the access walks the table again.
- R7: Walk results fill the entries in installation order. Once all `ENTRIES` entries are in use, each new installation replaces the entry installed earliest.
- R8: A cycle with `flush` high empties every entry and restarts the installation order. `ready` is low in that cycle, and the next access to any page walks the table.
- R9: While a walk is in progress `ready` is low, and `req_valid` has no effect. It produces no extra `done` or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| vaddr | input | VA_W | Virtual address (page number above offset) |
| ready | output | 1 | Request can be accepted this cycle |
| flush | input | 1 | Empty all buffer entries |
| pt_base | input | MA_W | Word address of page-table entry 0 |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MA_W | Page-table word address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | PFN_W+1 | Resident flag (top bit) and frame number |
| done | output | 1 | One-cycle pulse: translation finished |
| paddr | output | PFN_W+OFS_W | Physical address, valid with `done` |
| fault | output | 1 | One-cycle pulse: page not resident |
| fault_vpn | output | VPN_W | Page number that faulted, valid with `fault` |

## Verification
The bench drives hits at the first and last offset of a page. These catch a design that routes wrong bits into the offset, and one that lets a hit take an extra cycle or issue a needless read. It varies the memory latency from zero wait cycles to several, and checks that the address holds steady. A design that drops the request early, or fails to add the base, reads the wrong word. It faults the same page twice and then makes the page resident. A design that installs faulting entries would hit on the second try instead of walking again. It also fills the buffer past capacity, which exposes a replacement order that is not first-in first-out, and it flushes the buffer and then expects a miss. Finally, it holds `req_valid` high during a long walk. A design that accepts requests while busy would produce an unexpected result.

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VPN_W   = 8,
  parameter int OFS_W   = 8,
  parameter int PFN_W   = 6,
  parameter int ENTRIES = 4,
  parameter int MA_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W+OFS_W-1:0] vaddr,
  output logic                   ready,
  input  logic                   flush,
  input  logic [MA_W-1:0]        pt_base,
  output logic                   mem_req,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_ack,
  input  logic [PFN_W:0]         mem_rdata,
  output logic                   done,
  output logic [PFN_W+OFS_W-1:0] paddr,
  output logic                   fault,
  output logic [VPN_W-1:0]       fault_vpn
);
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   frm [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0]   hit_frm;
  logic [IDX_W-1:0]   wr_ptr;
  logic               walking;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFS_W-1:0]   ofs_q;

  wire [VPN_W-1:0] vpn_in = vaddr[VA_W-1:OFS_W];
  wire [OFS_W-1:0] ofs_in = vaddr[OFS_W-1:0];
  wire             accept = req_valid && ready;
  wire             any_hit = |hit_vec;
  wire             resident = mem_rdata[PFN_W];
  wire             fill = walking && mem_ack && resident;

  assign ready    = !walking && !flush;
  assign mem_req  = walking;
  assign mem_addr = pt_base + MA_W'(vpn_q);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag[i] == vpn_in);
  end

  always_comb begin
    hit_frm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_frm = hit_frm | frm[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      wr_ptr    <= '0;
      walking   <= 1'b0;
      vpn_q     <= '0;
      ofs_q     <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      paddr     <= '0;
      fault_vpn <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (accept) begin
        if (any_hit) begin
          done  <= 1'b1;
          paddr <= {hit_frm, ofs_in};
        end else begin
          walking <= 1'b1;
          vpn_q   <= vpn_in;
          ofs_q   <= ofs_in;
        end
      end
      if (walking && mem_ack) begin
        walking <= 1'b0;
        if (resident) begin
          done        <= 1'b1;
          paddr       <= {mem_rdata[PFN_W-1:0], ofs_q};
          vld[wr_ptr] <= 1'b1;
          wr_ptr      <= (wr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : wr_ptr + 1'b1;
        end else begin
          fault     <= 1'b1;
          fault_vpn <= vpn_q;
        end
      end
      if (flush) begin
        vld    <= '0;
        wr_ptr <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !flush) begin
      tag[wr_ptr] <= vpn_q;
      frm[wr_ptr] <= mem_rdata[PFN_W-1:0];
    end
  end

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> (done && !mem_req));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(mem_ack && !mem_rdata[PFN_W]));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);
endmodule

// File: tb/tb_xlate_unit.sv
module tb_xlate_unit;
  localparam int VPN_W = 8, OFS_W = 8, PFN_W = 6, ENT = 4, MA_W = 16;
  localparam int VA_W = VPN_W + OFS_W, PA_W = PFN_W + OFS_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, flush = 1'b0, mem_ack = 1'b0;
  logic [VA_W-1:0] vaddr = '0;
  logic [MA_W-1:0] pt_base = 16'h1200;
  logic [PFN_W:0] mem_rdata = '0;
  logic ready, mem_req, done, fault;
  logic [MA_W-1:0] mem_addr;
  logic [PA_W-1:0] paddr;
  logic [VPN_W-1:0] fault_vpn;

  xlate_unit #(.VPN_W(VPN_W), .OFS_W(OFS_W), .PFN_W(PFN_W), .ENTRIES(ENT), .MA_W(MA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr), .ready(ready),
    .flush(flush), .pt_base(pt_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .paddr(paddr),
    .fault(fault), .fault_vpn(fault_vpn));

  typedef struct {bit flt; logic [PA_W-1:0] pa; logic [VPN_W-1:0] fv; bit walk; int cyc;} exp_t;
  exp_t q[$];
  string tq[$];
  logic [VPN_W-1:0] mdl[$];
  bit pt_ok[256];
  int checks = 0, fails = 0, cyc = 0, lat_cfg = 1, ack_wait = 0;
  bit walked = 0;
  logic [VPN_W-1:0] cur_vpn = '0;
  logic [MA_W-1:0] held_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PFN_W-1:0] frame_of(input logic [VPN_W-1:0] v);
    return PFN_W'(v * 5 + 1);
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (done || fault) begin
      if (q.size() == 0) chk(0, "R9", "unexpected result", {done, fault}, 0);
      else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        chk(fault == e.flt, t, "fault flag", fault, e.flt);
        chk(done == !e.flt, t, "done flag", done, !e.flt);
        if (e.flt) chk(fault_vpn == e.fv, t, "fault_vpn", fault_vpn, e.fv);
        else begin
          chk(paddr == e.pa, t, "paddr", paddr, e.pa);
          chk(paddr[OFS_W-1:0] == e.pa[OFS_W-1:0], "R2", "offset", paddr[OFS_W-1:0], e.pa[OFS_W-1:0]);
        end
        chk(walked == e.walk, t, "table walk", walked, e.walk);
        if (e.cyc >= 0) chk(cyc == e.cyc, "R3", "hit latency", cyc, e.cyc);
        walked = 0;
      end
    end
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (ack_wait == 0) begin
        chk(mem_addr == pt_base + MA_W'(cur_vpn), "R4", "mem_addr", mem_addr, pt_base + MA_W'(cur_vpn));
        held_addr = mem_addr;
      end else chk(mem_addr == held_addr, "R4", "mem_addr held", mem_addr, held_addr);
      if (ack_wait >= lat_cfg) begin
        logic [VPN_W-1:0] v;
        v = VPN_W'(mem_addr - pt_base);
        mem_rdata = {pt_ok[v], frame_of(v)};
        mem_ack = 1'b1;
        ack_wait = 0;
        walked = 1;
      end else ack_wait++;
    end
  end

  task automatic present(input logic [VA_W-1:0] va, input string t);
    exp_t e;
    logic [VPN_W-1:0] v;
    bit hit;
    v = va[VA_W-1:OFS_W];
    while (!ready) @(negedge clk);
    hit = 0;
    foreach (mdl[i]) if (mdl[i] == v) hit = 1;
    e.walk = !hit; e.fv = v; e.cyc = -1;
    e.pa = {frame_of(v), va[OFS_W-1:0]};
    e.flt = !hit && !pt_ok[v];
    if (hit) e.cyc = cyc + 1;
    else if (pt_ok[v]) begin
      mdl.push_back(v);
      if (mdl.size() > ENT) void'(mdl.pop_front());
    end
    cur_vpn = v;
    q.push_back(e);
    tq.push_back(t);
    req_valid = 1'b1;
    vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic access(input logic [VA_W-1:0] va, input string t);
    present(va, t);
    drain();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pt_ok[i] = (i % 7) != 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fault, "R1", "outputs idle", {done, fault}, 0);
    chk(!mem_req, "R1", "mem_req idle", mem_req, 0);
    chk(ready, "R1", "ready after reset", ready, 1);
    access(16'h0512, "R1");
    access(16'h05FF, "R3");
    access(16'h0500, "R3");
    lat_cfg = 0; access(16'h0201, "R5");
    lat_cfg = 4; access(16'h0103, "R5");
    lat_cfg = 1;
    access(16'h0344, "R6");
    access(16'h0344, "R6");
    pt_ok[3] = 1;
    access(16'h0344, "R5");
    access(16'h0345, "R3");
    access(16'h0400, "R7");
    access(16'h0211, "R7");
    access(16'h0599, "R7");
    access(16'h0277, "R7");
    lat_cfg = 3;
    present(16'h0808, "R9");
    vaddr = 16'h0400;
    req_valid = 1'b1;
    chk(!ready, "R9", "ready during walk", ready, 0);
    @(negedge clk);
    chk(!ready, "R9", "ready during walk", ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    lat_cfg = 1;
    access(16'h0809, "R3");
    flush = 1'b1;
    #1 chk(!ready, "R8", "ready during flush", ready, 0);
    @(negedge clk);
    flush = 1'b0;
    mdl.delete();
    access(16'h0808, "R8");
    access(16'h0809, "R8");
    access(16'hFF00, "R6");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule